// File: doc/BRIEF.md
# Multirecord Sample Acquisition Engine

This block captures a parallel bus of input channels into an on-chip sample memory. Capture is split into records of a programmable length. A start pulse opens the first record at memory address zero. While a record is open, each sample the upstream source offers is written at the next address. When the record is full, the engine emits a one-cycle end-of-record pulse and stops accepting samples. It then waits for an advance trigger before it opens the next record, which is written directly after the previous one. When the programmed number of records is stored, a done flag rises and stays high until the next start pulse rearms the engine.

Samples arrive on a valid/ready stream. The source holds `smp_valid` and `smp_data` until it sees `smp_ready`. A sample is taken on every rising clock edge where both are high. The engine drives `smp_ready` high only while a record is open. Between records and after the final record it withholds ready, which is the only form of back-pressure it applies. Channels whose bit in `chan_en` is low are stored as zero. A registered read port returns stored samples so the stored data can be checked.

`rec_len`, `rec_count` and `chan_en` must stay stable from a start pulse until `done` rises. Write addresses wrap at the memory depth.

Top module: `multirec_acq`

## Requirements
- R1: After reset, `smp_ready`, `eor_pulse` and `done` are all low.
- R2: A `start` pulse while idle or done opens record 0 at address 0, and `smp_ready` is high in the cycle after the pulse.
- R3: Each accepted sample (`smp_valid` and `smp_ready` high at a clock edge) is stored at the address after the previous accepted sample, counting from 0 at each start.
- R4: A record holds exactly `rec_len` samples, and a value of 0 counts as 1. `smp_ready` stays high until the last sample of the record is accepted and is low in the cycle after.
- R5: `eor_pulse` is high for exactly one cycle, the cycle after the last sample of a record is written.
- R6: Between records `smp_ready` stays low until `adv_trig` is seen in the waiting state. It is high in the cycle after that trigger, and the next record continues at the following address.
- R7: An `adv_trig` that arrives while a record is open is ignored and does not release the following wait.
- R8: After `rec_count` records (0 counts as 1), `done` is high from the final end-of-record cycle onward. While `done` is high, `smp_ready` stays low and `adv_trig` has no effect.
- R9: A `start` pulse while done clears `done` and restarts capture at address 0.
- R10: A `start` pulse while a record is open or the engine is waiting is ignored.
- R11: `rd_data` shows the word at `rd_addr` one cycle after `rd_addr` is applied. A channel whose `chan_en` bit was low at capture reads as 0.
- R12: A cycle with `smp_valid` low stores nothing, does not advance the sample count, and keeps `smp_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens record 0 when idle or done |
| adv_trig | input | 1 | Opens the next record while waiting |
| rec_len | input | LEN_W | Samples per record (0 means 1) |
| rec_count | input | CNT_W | Records per run (0 means 1) |
| chan_en | input | CH | Per-channel capture enable |
| smp_valid | input | 1 | Source offers a sample |
| smp_data | input | CH | Channel states |
| smp_ready | output | 1 | Engine accepts a sample |
| eor_pulse | output | 1 | End-of-record event |
| done | output | 1 | All records captured |
| rd_addr | input | AW | Read address |
| rd_data | output | CH | Stored word, one cycle latency |

## Verification
The main capture path is driven with several record shapes: short records repeated many times, single-sample records, an odd length with a sparse channel mask, a run that fills the memory exactly, and a zero length. These separate errors in the sample count, the record count and the address carry across records. Runs with gaps inserted into the valid stream show whether idle cycles are wrongly stored or counted. Directed runs place a trigger inside an open record, a start inside an open record, a trigger after completion, and a rearm. Each of these shows whether a stray control pulse changes the state, the address or the event timing.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAPT = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } acq_state_t;
endpackage

// File: rtl/acq_ctrl.sv
module acq_ctrl
  import acq_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             adv_trig,
  input  logic [LEN_W-1:0] rec_len,
  input  logic [CNT_W-1:0] rec_count,
  input  logic             smp_fire,
  output acq_state_t       state,
  output logic             eor_pulse,
  output logic             restart
);
  logic [LEN_W-1:0] samp_cnt;
  logic [CNT_W-1:0] rec_idx;
  logic [LEN_W-1:0] eff_len;
  logic [CNT_W-1:0] eff_cnt;
  logic             last_smp;
  logic             last_rec;

  // A zero length or count is treated as one
  assign eff_len  = (rec_len == '0) ? LEN_W'(1) : rec_len;
  assign eff_cnt  = (rec_count == '0) ? CNT_W'(1) : rec_count;
  assign last_smp = (samp_cnt == eff_len - LEN_W'(1));
  assign last_rec = (rec_idx == eff_cnt - CNT_W'(1));
  assign restart  = start && (state == ST_IDLE || state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      samp_cnt  <= '0;
      rec_idx   <= '0;
      eor_pulse <= 1'b0;
    end else begin
      eor_pulse <= 1'b0;
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (restart) begin
            state    <= ST_CAPT;
            samp_cnt <= '0;
            rec_idx  <= '0;
          end
        end
        ST_CAPT: begin
          if (smp_fire) begin
            if (last_smp) begin
              samp_cnt  <= '0;
              eor_pulse <= 1'b1;
              if (last_rec) begin
                state <= ST_DONE;
              end else begin
                state   <= ST_WAIT;
                rec_idx <= rec_idx + CNT_W'(1);
              end
            end else begin
              samp_cnt <= samp_cnt + LEN_W'(1);
            end
          end
        end
        ST_WAIT: begin
          if (adv_trig) state <= ST_CAPT;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/acq_addr.sv
module acq_addr #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          advance,
  output logic [AW-1:0] wr_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) wr_addr <= '0;
    else if (advance)    wr_addr <= wr_addr + AW'(1);
  end
endmodule

// File: rtl/acq_mem.sv
module acq_mem #(
  parameter int CH    = 8,
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wr_addr,
  input  logic [CH-1:0] wr_data,
  input  logic [CH-1:0] chan_en,
  input  logic [AW-1:0] rd_addr,
  output logic [CH-1:0] rd_data
);
  logic [CH-1:0] mem [DEPTH];
  logic [CH-1:0] masked;

  for (genvar c = 0; c < CH; c++) begin : g_mask
    assign masked[c] = wr_data[c] & chan_en[c];
  end

  always_ff @(posedge clk) begin
    if (we) mem[wr_addr] <= masked;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/multirec_acq.sv
module multirec_acq
  import acq_pkg::*;
#(
  parameter int CH    = 8,
  parameter int DEPTH = 64,
  parameter int LEN_W = 8,
  parameter int CNT_W = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             adv_trig,
  input  logic [LEN_W-1:0] rec_len,
  input  logic [CNT_W-1:0] rec_count,
  input  logic [CH-1:0]    chan_en,
  input  logic             smp_valid,
  input  logic [CH-1:0]    smp_data,
  output logic             smp_ready,
  output logic             eor_pulse,
  output logic             done,
  input  logic [AW-1:0]    rd_addr,
  output logic [CH-1:0]    rd_data
);
  acq_state_t    state;
  logic          restart;
  logic          smp_fire;
  logic [AW-1:0] wr_addr;

  assign smp_ready = (state == ST_CAPT);
  assign done      = (state == ST_DONE);
  assign smp_fire  = smp_valid && smp_ready;

  acq_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .adv_trig(adv_trig),
    .rec_len(rec_len), .rec_count(rec_count), .smp_fire(smp_fire),
    .state(state), .eor_pulse(eor_pulse), .restart(restart)
  );

  acq_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .clear(restart), .advance(smp_fire),
    .wr_addr(wr_addr)
  );

  acq_mem #(.CH(CH), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .we(smp_fire), .wr_addr(wr_addr), .wr_data(smp_data),
    .chan_en(chan_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/multirec_acq_chk.sv
module multirec_acq_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          smp_valid,
  input logic          smp_ready,
  input logic          eor_pulse,
  input logic          done,
  input logic [AW-1:0] wr_addr
);
  AST_EOR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eor_pulse |=> !eor_pulse); // R5
  AST_EOR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    eor_pulse |-> $past(smp_valid && smp_ready)); // R5
  AST_WAIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (eor_pulse && !done) |-> !smp_ready); // R6
  AST_NO_READY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !smp_ready); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R8
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_ready) |=> (wr_addr == AW'($past(wr_addr) + AW'(1)))); // R3
  AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_ready && !smp_valid) |=> (smp_ready && $stable(wr_addr))); // R12
endmodule

bind multirec_acq multirec_acq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .smp_valid(smp_valid),
  .smp_ready(smp_ready), .eor_pulse(eor_pulse), .done(done), .wr_addr(wr_addr)
);

// File: tb/multirec_acq_bench.sv
`timescale 1ns/1ps
module multirec_acq_bench;
  localparam int CH = 8, DEPTH = 64, LEN_W = 8, CNT_W = 8, AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, adv_trig = 1'b0, smp_valid = 1'b0;
  logic [LEN_W-1:0] rec_len = '0;
  logic [CNT_W-1:0] rec_count = '0;
  logic [CH-1:0] chan_en = '0, smp_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic smp_ready, eor_pulse, done;
  logic [CH-1:0] rd_data;

  int checks = 0, errors = 0;
  logic [CH-1:0] exp_mem [DEPTH];

  // {len, count, enable mask, gap flag}
  localparam logic [31:0] TBL [5] = '{
    {8'd4,  8'd3, 8'hFF, 8'd0},
    {8'd1,  8'd5, 8'h0F, 8'd1},
    {8'd7,  8'd2, 8'hA5, 8'd1},
    {8'd16, 8'd4, 8'hFF, 8'd0},
    {8'd0,  8'd3, 8'h3C, 8'd0}
  };

  always #5 clk = ~clk;

  multirec_acq #(.CH(CH), .DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_multirec_acq (
    .clk(clk), .rst_n(rst_n), .start(start), .adv_trig(adv_trig),
    .rec_len(rec_len), .rec_count(rec_count), .chan_en(chan_en),
    .smp_valid(smp_valid), .smp_data(smp_data), .smp_ready(smp_ready),
    .eor_pulse(eor_pulse), .done(done), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [CH-1:0] gen(input int seed, input int i);
    return CH'(seed * 13 + i * 29 + 7);
  endfunction

  task automatic readback(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      rd_addr = AW'(i);
      step();
      chk(rd_data == exp_mem[i], req, rd_data, exp_mem[i]);
    end
  endtask

  task automatic run_capture(input int len, input int cnt, input logic [7:0] en,
                             input bit gap, input int seed);
    int eff_len, eff_cnt, idx;
    eff_len = (len == 0) ? 1 : len;
    eff_cnt = (cnt == 0) ? 1 : cnt;
    rec_len = LEN_W'(len); rec_count = CNT_W'(cnt); chan_en = en;
    start = 1'b1; step(); start = 1'b0;
    chk(smp_ready == 1'b1 && done == 1'b0, "R2 ready after start", smp_ready, 1);
    idx = 0;
    for (int r = 0; r < eff_cnt; r++) begin
      for (int s = 0; s < eff_len; s++) begin
        if (gap && s[0]) begin
          smp_valid = 1'b0; step();
          chk(smp_ready == 1'b1 && eor_pulse == 1'b0, "R12 gap keeps ready", smp_ready, 1);
        end
        smp_data = gen(seed, idx);
        exp_mem[idx] = smp_data & en;
        idx++;
        smp_valid = 1'b1; step(); smp_valid = 1'b0;
        if (s < eff_len - 1)
          chk(smp_ready == 1'b1 && eor_pulse == 1'b0, "R4 record still open", smp_ready, 1);
        else begin
          chk(eor_pulse == 1'b1, "R5 eor after last sample", eor_pulse, 1);
          chk(smp_ready == 1'b0, "R4 ready drops at record end", smp_ready, 0);
        end
      end
      if (r < eff_cnt - 1) begin
        chk(done == 1'b0, "R6 not done between records", done, 0);
        step();
        chk(eor_pulse == 1'b0, "R5 eor one cycle", eor_pulse, 0);
        step();
        chk(smp_ready == 1'b0, "R6 waits for trigger", smp_ready, 0);
        adv_trig = 1'b1; step(); adv_trig = 1'b0;
        chk(smp_ready == 1'b1, "R6 trigger opens record", smp_ready, 1);
      end else begin
        chk(done == 1'b1, "R8 done with final eor", done, 1);
      end
    end
    step();
    readback(idx, "R3 R11 stored data");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [CH-1:0] v;
    step();
    chk(smp_ready == 0 && eor_pulse == 0 && done == 0, "R1 during reset", smp_ready, 0);
    step(); rst_n = 1'b1; step();
    chk(smp_ready == 0 && eor_pulse == 0 && done == 0, "R1 after reset", done, 0);

    // Table of record shapes
    for (int t = 0; t < 5; t++)
      run_capture(int'(TBL[t][31:24]), int'(TBL[t][23:16]), TBL[t][15:8], TBL[t][7:0] != 0, t + 1);

    // R7: trigger inside an open record is ignored
    rec_len = 3; rec_count = 2; chan_en = 8'hFF;
    start = 1'b1; step(); start = 1'b0;
    for (int s = 0; s < 3; s++) begin
      smp_data = gen(9, s); smp_valid = 1'b1; adv_trig = (s == 0);
      step(); adv_trig = 1'b0;
    end
    smp_valid = 1'b0;
    chk(eor_pulse == 1'b1, "R7 record ends normally", eor_pulse, 1);
    step(); step(); step();
    chk(smp_ready == 1'b0, "R7 early trigger not kept", smp_ready, 0);
    // R10: start while waiting is ignored
    start = 1'b1; step(); start = 1'b0;
    chk(smp_ready == 1'b0 && done == 1'b0, "R10 start while waiting", smp_ready, 0);
    adv_trig = 1'b1; step(); adv_trig = 1'b0;
    for (int s = 0; s < 3; s++) begin
      smp_data = gen(9, s + 3); smp_valid = 1'b1; step();
    end
    smp_valid = 1'b0;
    chk(done == 1'b1, "R7 second record completes", done, 1);

    // R10: start inside an open record is ignored
    rec_len = 4; rec_count = 1;
    start = 1'b1; step(); start = 1'b0;
    for (int s = 0; s < 4; s++) begin
      smp_data = gen(11, s); exp_mem[s] = smp_data;
      smp_valid = 1'b1; start = (s == 1); step(); start = 1'b0;
      if (s == 2) chk(eor_pulse == 1'b0 && smp_ready == 1'b1, "R10 count not reset", eor_pulse, 0);
    end
    smp_valid = 1'b0;
    chk(eor_pulse == 1'b1 && done == 1'b1, "R10 eor at original length", eor_pulse, 1);
    step();
    readback(4, "R10 addresses unbroken");

    // R8: trigger after done has no effect
    adv_trig = 1'b1; step(); adv_trig = 1'b0; step();
    chk(smp_ready == 1'b0 && done == 1'b1, "R8 trigger after done", smp_ready, 0);
    smp_valid = 1'b1; smp_data = 8'h5A; step(); smp_valid = 1'b0;
    rd_addr = 0; step();
    chk(rd_data == exp_mem[0], "R8 no write after done", rd_data, exp_mem[0]);

    // R9: rearm from done restarts at address 0
    rec_len = 1; rec_count = 1; chan_en = 8'hF0;
    start = 1'b1; step(); start = 1'b0;
    chk(done == 1'b0 && smp_ready == 1'b1, "R9 rearm clears done", done, 0);
    v = 8'hC3; smp_data = v; smp_valid = 1'b1; step(); smp_valid = 1'b0;
    chk(eor_pulse == 1'b1 && done == 1'b1, "R9 rearmed run completes", done, 1);
    rd_addr = 0; step();
    chk(rd_data == (v & 8'hF0), "R9 R11 written at address 0 masked", rd_data, v & 8'hF0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule